// File: doc/BRIEF.md
# Quadrature Numerically Controlled Oscillator with Folded Quarter-Wave Table

This block produces a pair of signed digital sinusoids, one sine and one cosine, whose frequency is set by a tuning word. An 8-bit phase register advances by the tuning word on every clock and wraps at 256. The output frequency is therefore the tuning word times the clock rate divided by 256. At a 50 MHz clock, a word of 51 gives about 9.96 MHz. A new word can be loaded at any time with a one-cycle strobe. The clock and the stored waveform stay as they are.

Only a quarter of one sine period is held in storage. That quarter is split between two small ROMs, each holding half of it. The full sine is rebuilt by mirroring the index inside odd quadrants and negating in the second half-turn. The cosine comes from the same folding applied to the phase shifted by a quarter turn. Both outputs are registered. A valid flag marks when the pipeline holds real samples after reset.

Top module: `nco_quad_top`

## Requirements
- R1: While rst_n is low, sample_valid is 0 and both samples are 0. Reset clears the phase and the tuning word, so with no load after reset the phase stays at 0.
- R2: At each rising clock edge out of reset, phase becomes (phase + tuning word) mod 256.
- R3: When ftw_load is high at an edge, ftw_in is stored at that edge. The first phase step that uses it happens at the following edge.
- R4: The quarter table holds, for index i in 0..63, the magnitude round(2047 * sin(2*pi*(i+0.5)/256)). Index bit 5 selects the ROM half and bits 4:0 address within it.
- R5: For phase p, the sine sample is m(k) with k = p[5:0], or k = 63 - p[5:0] when p[6] = 1. The sample is negated when p[7] = 1. This equals round(2047*|sin(2*pi*(p+0.5)/256)|) with the sign of that sine.
- R6: The cosine sample for phase p equals the sine sample rule applied to (p + 64) mod 256.
- R7: The samples present after edge k+2 belong to the phase value held after edge k, a fixed latency of two clocks.
- R8: sample_valid rises after the second rising edge following reset release and stays high until the next reset.
- R9: Samples are 12-bit two's complement and never take the value -2048.
- R10: With a tuning word of 0 the phase, and therefore both samples, hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with clk |
| ftw_load | input | 1 | Strobe that captures a new tuning word |
| ftw_in | input | 8 | Tuning word to capture |
| sin_o | output | 12 | Signed sine sample |
| cos_o | output | 12 | Signed cosine sample |
| sample_valid | output | 1 | High once the output pipeline holds samples |

## Verification
A new tuning word changes the phase one edge after the edge that loads it. A phase value reaches the sample outputs two edges after it is formed, and valid appears two edges after reset is released. The bench keeps its own phase history, updated at each rising edge with the same ordering. It compares the outputs a quarter period later against the phase from two edges back, and compares valid against its own count of edges since reset. Sweeps with words 1, 51, 255, 128 and 0 cover every phase value for both outputs. The expected samples are computed with a real-valued sine.

// File: rtl/nco_pkg.sv
package nco_pkg;
  // Magnitude of the quarter-wave sample at index idx for a table of
  // 2**qbits entries, evaluated at half-step offsets (elaboration only).
  function automatic int quarter_mag(input int idx, input int qbits, input int amp);
    real x;
    real term;
    real acc;
    x = 2.0 * 3.14159265358979323846 * (real'(idx) + 0.5) / real'(4 * (1 << qbits));
    term = x;
    acc = x;
    for (int k = 1; k < 14; k++) begin
      term = -term * x * x / real'((2 * k) * (2 * k + 1));
      acc = acc + term;
    end
    return $rtoi(real'(amp) * acc + 0.5);
  endfunction
endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [PW-1:0] ftw_in,
  output logic [PW-1:0] phase_o,
  output logic [PW-1:0] ftw_o
);
  logic [PW-1:0] phase_q, phase_d;
  logic [PW-1:0] ftw_q, ftw_d;

  always_comb begin
    phase_d = phase_q + ftw_q;
    ftw_d   = ftw_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      ftw_q   <= '0;
    end else begin
      phase_q <= phase_d;
      if (load) ftw_q <= ftw_d;
    end
  end

  assign phase_o = phase_q;
  assign ftw_o   = ftw_q;
endmodule

// File: rtl/nco_rom_half.sv
module nco_rom_half #(
  parameter int QW    = 6,
  parameter int MW    = 11,
  parameter int HALF  = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [QW-2:0] addr,
  output logic [MW-1:0] data_o
);
  import nco_pkg::*;
  localparam int DEPTH = 1 << (QW - 1);
  localparam int AMP   = (1 << MW) - 1;

  logic [MW-1:0] table_w [DEPTH];
  logic [MW-1:0] data_q, data_d;

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    localparam int VAL = quarter_mag(HALF * DEPTH + i, QW, AMP);
    assign table_w[i] = VAL[MW-1:0];
  end

  always_comb data_d = table_w[addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else        data_q <= data_d;
  end

  assign data_o = data_q;
endmodule

// File: rtl/nco_fold_lookup.sv
module nco_fold_lookup #(
  parameter int PW = 8,
  parameter int SW = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PW-1:0]        phase,
  output logic signed [SW-1:0] sample_o
);
  localparam int QW = PW - 2;
  localparam int MW = SW - 1;

  logic [QW-1:0] idx;
  logic          neg_q, sel_q;
  logic [MW-1:0] half_data [2];
  logic [MW-1:0] mag;
  logic signed [SW-1:0] sample_q, sample_d;

  // Quadrant fold: mirror inside odd quadrants.
  always_comb idx = phase[QW-1:0] ^ {QW{phase[PW-2]}};

  for (genvar h = 0; h < 2; h++) begin : g_half
    nco_rom_half #(.QW(QW), .MW(MW), .HALF(h)) u_rom (
      .clk    (clk),
      .rst_n  (rst_n),
      .addr   (idx[QW-2:0]),
      .data_o (half_data[h])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_q <= 1'b0;
      sel_q <= 1'b0;
    end else begin
      neg_q <= phase[PW-1];
      sel_q <= idx[QW-1];
    end
  end

  always_comb begin
    mag      = sel_q ? half_data[1] : half_data[0];
    sample_d = neg_q ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sample_q <= '0;
    else        sample_q <= sample_d;
  end

  assign sample_o = sample_q;
endmodule

// File: rtl/nco_quad_top.sv
module nco_quad_top #(
  parameter int PW = 8,
  parameter int SW = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ftw_load,
  input  logic [PW-1:0]        ftw_in,
  output logic signed [SW-1:0] sin_o,
  output logic signed [SW-1:0] cos_o,
  output logic                 sample_valid
);
  localparam int          LAT     = 2;
  localparam logic [PW-1:0] QUARTER = PW'(1 << (PW - 2));

  logic [PW-1:0] phase_w, ftw_w, cos_phase;
  logic [LAT-1:0] fill_q, fill_d;

  nco_phase_acc #(.PW(PW)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ftw_load),
    .ftw_in  (ftw_in),
    .phase_o (phase_w),
    .ftw_o   (ftw_w)
  );

  always_comb cos_phase = phase_w + QUARTER;

  nco_fold_lookup #(.PW(PW), .SW(SW)) u_sin (
    .clk (clk), .rst_n (rst_n), .phase (phase_w), .sample_o (sin_o)
  );

  nco_fold_lookup #(.PW(PW), .SW(SW)) u_cos (
    .clk (clk), .rst_n (rst_n), .phase (cos_phase), .sample_o (cos_o)
  );

  always_comb fill_d = {fill_q[LAT-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fill_q <= '0;
    else        fill_q <= fill_d;
  end

  assign sample_valid = fill_q[LAT-1];
endmodule

// File: rtl/nco_quad_checker.sv
module nco_quad_checker #(
  parameter int PW = 8,
  parameter int SW = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ftw_load,
  input logic [PW-1:0]        ftw_in,
  input logic [PW-1:0]        phase,
  input logic [PW-1:0]        ftw,
  input logic signed [SW-1:0] sin_s,
  input logic signed [SW-1:0] cos_s,
  input logic                 valid
);
  localparam int AMP = (1 << (SW - 1)) - 1;
  localparam logic signed [SW-1:0] MOST_NEG = {1'b1, {(SW-1){1'b0}}};

  int abs_sum;
  always_comb begin
    abs_sum = (sin_s < 0 ? -int'(sin_s) : int'(sin_s)) +
              (cos_s < 0 ? -int'(cos_s) : int'(cos_s));
  end

  // R3
  a_r3_word_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ftw_load |=> ftw == $past(ftw_in));

  // R10
  a_r10_zero_word_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ftw == '0) |=> $stable(phase));

  // R9
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (sin_s != MOST_NEG) && (cos_s != MOST_NEG));

  // R6
  a_r6_quadrature_energy: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> abs_sum >= AMP - 1);

  // R8
  a_r8_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> valid);
endmodule

bind nco_quad_top nco_quad_checker #(.PW(PW), .SW(SW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ftw_load (ftw_load),
  .ftw_in   (ftw_in),
  .phase    (phase_w),
  .ftw      (ftw_w),
  .sin_s    (sin_o),
  .cos_s    (cos_o),
  .valid    (sample_valid)
);

// File: tb/tb_nco_quad_top.sv
module tb_nco_quad_top;
  logic              clk;
  logic              rst_n;
  logic              ftw_load;
  logic [7:0]        ftw_in;
  logic signed [11:0] sin_o, cos_o;
  logic              sample_valid;

  int checks;
  int failures;
  bit done;
  string seg_tag;

  // bench model
  int m_phase, m_ftw, d1, d2, edges;

  nco_quad_top dut (
    .clk (clk), .rst_n (rst_n), .ftw_load (ftw_load), .ftw_in (ftw_in),
    .sin_o (sin_o), .cos_o (cos_o), .sample_valid (sample_valid)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int exp_sample(input int p);
    real s;
    int  m;
    s = $sin(2.0 * 3.14159265358979323846 * (real'(p % 256) + 0.5) / 256.0);
    m = $rtoi(2047.0 * (s < 0.0 ? -s : s) + 0.5);
    return (s < 0.0) ? -m : m;
  endfunction

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  // Model update at each edge, checks a quarter period later.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_ftw = 0; d1 = 0; d2 = 0; edges = 0;
    end else begin
      d2 = d1;                                 // R7: two-register delay
      d1 = m_phase;
      m_phase = (m_phase + m_ftw) % 256;       // R2
      if (ftw_load) m_ftw = int'(ftw_in);      // R3: used from next edge
      if (edges < 1000) edges++;
    end
    #5;
    if (!done) begin
      if (!rst_n) begin
        check("R1 valid in reset", int'(sample_valid), 0);
        check("R1 sine in reset", int'(sin_o), 0);
        check("R1 cosine in reset", int'(cos_o), 0);
      end else begin
        check("R8 valid timing", int'(sample_valid), (edges >= 2) ? 1 : 0);
        if (edges >= 2) begin
          check({seg_tag, " R4 R5 R7 sine"}, int'(sin_o), exp_sample(d2));
          check({seg_tag, " R6 cosine"}, int'(cos_o), exp_sample(d2 + 64));
          check("R9 range", (int'(sin_o) == -2048 || int'(cos_o) == -2048) ? 1 : 0, 0);
        end
      end
    end
  end

  task automatic load_word(input int w);
    @(negedge clk);
    ftw_in = 8'(w);
    ftw_load = 1'b1;
    @(negedge clk);
    ftw_load = 1'b0;
  endtask

  initial begin
    checks = 0; failures = 0; done = 0;
    seg_tag = "R1 R10 idle";
    rst_n = 1'b0; ftw_load = 1'b0; ftw_in = 8'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);            // zero word: phase held at 0
    seg_tag = "R2 R3 step1";
    load_word(1);
    repeat (262) @(negedge clk);          // every phase for both outputs
    seg_tag = "R2 R3 step51";
    load_word(51);
    repeat (70) @(negedge clk);
    seg_tag = "R2 R3 step255";
    load_word(255);
    repeat (40) @(negedge clk);
    seg_tag = "R2 R3 step128";
    load_word(128);
    repeat (10) @(negedge clk);
    seg_tag = "R10 hold";
    load_word(0);
    repeat (10) @(negedge clk);
    seg_tag = "R1 R8 rerun";
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    load_word(3);
    repeat (30) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule